// File: doc/BRIEF.md
# Multi-Channel Memory-Mapped Register Slave

This block is a synchronous bus slave that serves a set of independent register channels. Each channel is set up at build time to one of five access styles. An output channel holds a register that a bus write loads and that drives a top-level pin group. An input channel samples a pin group through a two-flop synchronizer and returns it on a bus read. A loopback channel drives its pins and also returns the register contents on a read. A disabled channel does nothing.

Input channels watch their synchronized bits for 0-to-1 transitions. Each such transition is latched in a per-channel capture register, and a per-channel mask decides which captured bits raise the shared interrupt. Software clears captured bits by writing ones to them. For every channel the block also gives attached user logic a select strobe, plus read and write qualified copies, whenever the bus touches that channel's data word. The read strobe can serve directly as the read acknowledge of an external FIFO that feeds an input pin group.

Reads return data one cycle after the read cycle. All state clears under a synchronous active-high reset.

Top module: `mmio_chan_regs`

## Requirements
- R1: While `rst` is high at a rising edge, every output register, mask, capture register, `rdata` and `irq` become zero.
- R2: A write to word 0 of a channel whose mode code is 1 (output only), 3 (output and input) or 4 (output with loopback) loads that channel's output register. The register drives `pin_out[ch*DW +: DW]` from the next edge on. `pin_out` changes only in the cycle after a bus write.
- R3: A data-word read of a loopback channel (code 4) returns its output register. A data-word read of an output-only channel (code 1) returns zero.
- R4: A data-word read of an input channel (code 2 input only, code 3 output and input) returns `pin_in[ch*DW +: DW]` after a two-flop synchronizer. A read issued three or more edges after a pin change returns the new value.
- R5: A disabled channel (code 0), or a channel index of `NUM_CH` or above, drives zero on its pins, ignores writes and reads as zero.
- R6: `rdata` carries the read value in the cycle after a cycle with `cs` and `rd` high, and is zero in every other cycle.
- R7: In input channels, word 2 is the capture register. A bit sets when the synchronized input bit goes from 0 to 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: In input channels, word 1 is a read/write interrupt mask. Other modes read this word as zero and ignore writes to it. `irq` is the OR over channels of capture AND mask, only when `DW` is 32 or less. It stays high until software clears the capture bits or the mask.
- R9: `usr_sel[i]` is high in the same cycle as `cs` with channel i and word 0 addressed. `usr_rd[i]` and `usr_wr[i]` are that strobe qualified by `rd` and `wr`. At most one `usr_sel` bit is high.
- R10: `addr[1:0]` selects the word (0 data, 1 mask, 2 capture, 3 reserved and reading zero), and the upper address bits select the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | CH_W+2 | Channel in upper bits, word in low two bits |
| cs | input | 1 | Slave select |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| pin_in | input | NUM_CH*DW | Input pin groups, channel i at bits i*DW |
| pin_out | output | NUM_CH*DW | Output pin groups, channel i at bits i*DW |
| usr_sel | output | NUM_CH | Per-channel data-word select strobe |
| usr_rd | output | NUM_CH | Per-channel read strobe |
| usr_wr | output | NUM_CH | Per-channel write strobe |
| irq | output | 1 | Masked rising-edge interrupt |

## Verification
The default build holds one channel of each mode plus unmapped channel indices, so that the same bus operation can be compared across modes. Random writes, reads and pin changes, aimed at every word of every channel index, show whether data lands only where the mode permits it and whether reads of absent paths stay zero. Pin patterns that raise some bits and drop others show whether the capture register records only rising transitions. Directed steps write zeros and then ones to the capture word, and write the mask, to show that clearing is per bit and that `irq` follows the masked capture state.

// File: rtl/mmio_chan_pkg.sv
package mmio_chan_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_OUT   = 3'd1,
    MODE_IN    = 3'd2,
    MODE_INOUT = 3'd3,
    MODE_LOOP  = 3'd4
  } chan_mode_e;

  localparam int MAX_CH = 16;

  localparam logic [1:0] WORD_DATA = 2'd0;
  localparam logic [1:0] WORD_MASK = 2'd1;
  localparam logic [1:0] WORD_CAP  = 2'd2;

  // mode of channel ch from the packed 3-bit-per-channel parameter
  function automatic chan_mode_e mode_of(input logic [3*MAX_CH-1:0] modes, input int ch);
    return chan_mode_e'(modes[ch*3 +: 3]);
  endfunction

  function automatic bit has_out(input chan_mode_e m);
    return (m == MODE_OUT) || (m == MODE_INOUT) || (m == MODE_LOOP);
  endfunction

  function automatic bit has_in(input chan_mode_e m);
    return (m == MODE_IN) || (m == MODE_INOUT);
  endfunction

  // interrupt term of one channel; interrupts exist only for widths up to 32
  function automatic logic irq_term(input logic [31:0] cap, input logic [31:0] mask);
    return |(cap & mask);
  endfunction

endpackage

// File: rtl/mmio_chan_decode.sv
module mmio_chan_decode
  import mmio_chan_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3
) (
  input  logic [CH_W+1:0]   addr,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  output logic [1:0]        word,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [NUM_CH-1:0] wr_ch,
  output logic [NUM_CH-1:0] usr_sel,
  output logic [NUM_CH-1:0] usr_rd,
  output logic [NUM_CH-1:0] usr_wr
);

  assign word = addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i]  = cs && (addr[CH_W+1:2] == CH_W'(i));
    assign wr_ch[i]   = ch_hit[i] && wr;
    assign usr_sel[i] = ch_hit[i] && (word == WORD_DATA);
    assign usr_rd[i]  = usr_sel[i] && rd;
    assign usr_wr[i]  = usr_sel[i] && wr;
  end

endmodule

// File: rtl/mmio_chan_pair.sv
module mmio_chan_pair
  import mmio_chan_pkg::*;
#(
  parameter int         DW     = 16,
  parameter chan_mode_e MODE   = MODE_OFF,
  parameter bit         IRQ_ON = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    word,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] rise,
  output logic          irq
);

  localparam bit HAS_OUT = has_out(MODE);
  localparam bit HAS_IN  = has_in(MODE);
  localparam bit HAS_IRQ = HAS_IN && IRQ_ON;

  logic [DW-1:0] out_q;
  logic [DW-1:0] in_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] cap_q;

  logic unused_misc;
  assign unused_misc = ^{clk, rst, wr_en, word, wdata, pin_in};

  if (HAS_OUT) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)                             out_q <= '0;
      else if (wr_en && word == WORD_DATA) out_q <= wdata;
    end
  end else begin : g_no_out
    assign out_q = '0;
  end

  if (HAS_IN) begin : g_in
    logic [DW-1:0] meta_q;
    logic [DW-1:0] prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= '0;
        in_q   <= '0;
        prev_q <= '0;
      end else begin
        meta_q <= pin_in;
        in_q   <= meta_q;
        prev_q <= in_q;
      end
    end
    assign rise = in_q & ~prev_q;
  end else begin : g_no_in
    assign in_q = '0;
    assign rise = '0;
  end

  if (HAS_IRQ) begin : g_irq
    logic [DW-1:0] clr;
    assign clr = (wr_en && word == WORD_CAP) ? wdata : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= '0;
        cap_q  <= '0;
      end else begin
        if (wr_en && word == WORD_MASK) mask_q <= wdata;
        cap_q <= (cap_q & ~clr) | rise;
      end
    end
    assign irq = irq_term(32'(cap_q), 32'(mask_q));
  end else begin : g_no_irq
    assign mask_q = '0;
    assign cap_q  = '0;
    assign irq    = 1'b0;
  end

  always_comb begin
    unique case (word)
      WORD_DATA: rd_word = HAS_IN ? in_q : ((MODE == MODE_LOOP) ? out_q : '0);
      WORD_MASK: rd_word = mask_q;
      WORD_CAP:  rd_word = cap_q;
      default:   rd_word = '0;
    endcase
  end

  assign pin_out = out_q;

endmodule

// File: rtl/mmio_chan_rdmux.sv
module mmio_chan_rdmux #(
  parameter int NUM_CH = 5,
  parameter int DW     = 16
) (
  input  logic [NUM_CH-1:0]    ch_hit,
  input  logic [NUM_CH*DW-1:0] words,
  output logic [DW-1:0]        sel_word
);

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) sel_word = sel_word | words[i*DW +: DW];
    end
  end

endmodule

// File: rtl/mmio_chan_regs.sv
module mmio_chan_regs
  import mmio_chan_pkg::*;
#(
  parameter int                  NUM_CH   = 5,
  parameter int                  DW       = 16,
  parameter logic [3*MAX_CH-1:0] CH_MODES = 48'h88B,
  localparam int                 CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int                 AW       = CH_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr,
  input  logic                 cs,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_CH*DW-1:0] pin_in,
  output logic [NUM_CH*DW-1:0] pin_out,
  output logic [NUM_CH-1:0]    usr_sel,
  output logic [NUM_CH-1:0]    usr_rd,
  output logic [NUM_CH-1:0]    usr_wr,
  output logic                 irq
);

  localparam bit IRQ_ON = (DW <= 32);

  logic [1:0]           word;
  logic [NUM_CH-1:0]    ch_hit;
  logic [NUM_CH-1:0]    wr_ch;
  logic [NUM_CH-1:0]    irq_ch;
  logic [NUM_CH*DW-1:0] rd_words;
  logic [NUM_CH*DW-1:0] rise_all;
  logic [DW-1:0]        rd_next;

  mmio_chan_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .addr    (addr),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .word    (word),
    .ch_hit  (ch_hit),
    .wr_ch   (wr_ch),
    .usr_sel (usr_sel),
    .usr_rd  (usr_rd),
    .usr_wr  (usr_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mmio_chan_pair #(
      .DW     (DW),
      .MODE   (mode_of(CH_MODES, i)),
      .IRQ_ON (IRQ_ON)
    ) u_pair (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_ch[i]),
      .word    (word),
      .wdata   (wdata),
      .pin_in  (pin_in[i*DW +: DW]),
      .pin_out (pin_out[i*DW +: DW]),
      .rd_word (rd_words[i*DW +: DW]),
      .rise    (rise_all[i*DW +: DW]),
      .irq     (irq_ch[i])
    );
  end

  mmio_chan_rdmux #(.NUM_CH(NUM_CH), .DW(DW)) u_mux (
    .ch_hit   (ch_hit),
    .words    (rd_words),
    .sel_word (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (cs && rd)  rdata <= rd_next;
    else                rdata <= '0;
  end

  assign irq = |irq_ch;

endmodule

// File: rtl/mmio_chan_regs_chk.sv
module mmio_chan_regs_chk #(
  parameter int NUM_CH = 5,
  parameter int DW     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs,
  input logic                 rd,
  input logic                 wr,
  input logic [DW-1:0]        rdata,
  input logic [NUM_CH*DW-1:0] pin_out,
  input logic [NUM_CH-1:0]    usr_sel,
  input logic [NUM_CH-1:0]    usr_rd,
  input logic [NUM_CH-1:0]    usr_wr,
  input logic                 irq,
  input logic [NUM_CH*DW-1:0] rise_all
);

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(usr_sel));

  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (|usr_rd) |-> (cs && rd));

  p_wr_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (|usr_wr) |-> (cs && wr));

  p_rdata_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && rd) |-> (rdata == '0));

  p_pins_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && wr) |-> $stable(pin_out));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(cs && wr));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(|rise_all) || $past(cs && wr)));

endmodule

bind mmio_chan_regs mmio_chan_regs_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (.*);

// File: tb/mmio_chan_regs_tb.sv
`timescale 1ns/1ps
module mmio_chan_regs_tb;

  localparam int NUM_CH = 5;
  localparam int DW     = 16;
  localparam int CH_W   = 3;
  localparam int AW     = CH_W + 2;
  localparam int NW     = NUM_CH * DW;
  localparam logic [47:0] MODES = 48'h88B; // ch0 io, ch1 out, ch2 in, ch3 loop, ch4 off

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr;
  logic cs, rd, wr;
  logic [DW-1:0] wdata, rdata;
  logic [NW-1:0] pin_in, pin_out;
  logic [NUM_CH-1:0] usr_sel, usr_rd, usr_wr;
  logic irq;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  logic [DW-1:0] m_out  [NUM_CH];
  logic [DW-1:0] m_pin  [NUM_CH];
  logic [DW-1:0] m_mask [NUM_CH];
  logic [DW-1:0] m_cap  [NUM_CH];

  always #2.5 clk = ~clk;

  mmio_chan_regs #(.NUM_CH(NUM_CH), .DW(DW), .CH_MODES(MODES)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .cs(cs), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .usr_sel(usr_sel), .usr_rd(usr_rd), .usr_wr(usr_wr), .irq(irq)
  );

  function automatic int mode_code(input int ch);
    return (ch < NUM_CH) ? int'((MODES >> (3 * ch)) & 48'h7) : 0;
  endfunction
  function automatic bit b_out(input int ch);
    int m = mode_code(ch);
    return (m == 1) || (m == 3) || (m == 4);
  endfunction
  function automatic bit b_in(input int ch);
    int m = mode_code(ch);
    return (m == 2) || (m == 3);
  endfunction

  function automatic logic [NW-1:0] exp_pins();
    logic [NW-1:0] v = '0;
    for (int c = 0; c < NUM_CH; c++) if (b_out(c)) v[c*DW +: DW] = m_out[c];
    return v;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (b_in(c)) r = r | (|(m_cap[c] & m_mask[c]));
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int ch, input int w);
    if (ch >= NUM_CH) return '0;
    case (w)
      0: return b_in(ch) ? m_pin[ch] : ((mode_code(ch) == 4) ? m_out[ch] : '0);
      1: return b_in(ch) ? m_mask[ch] : '0;
      2: return b_in(ch) ? m_cap[ch] : '0;
      default: return '0;
    endcase
  endfunction

  function automatic string read_tag(input int ch, input int w);
    if (w == 3) return "R10 reserved word";
    if (ch >= NUM_CH || mode_code(ch) == 0) return "R5 absent channel";
    if (w == 1) return "R8 mask read";
    if (w == 2) return "R7 capture read";
    if (b_in(ch)) return "R4 input read";
    return "R3 output readback";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int ch, input int w, input logic [DW-1:0] d);
    logic [NUM_CH-1:0] es;
    @(negedge clk);
    addr = AW'(ch * 4 + w); wdata = d; cs = 1'b1; wr = 1'b1;
    #1;
    es = (ch < NUM_CH && w == 0) ? NUM_CH'(1 << ch) : '0;
    check(usr_wr == es && usr_sel == es && usr_rd == '0, "R9 write strobes",
          128'({usr_sel, usr_rd, usr_wr}), 128'({es, {NUM_CH{1'b0}}, es}));
    if (ch < NUM_CH) begin
      if (w == 0 && b_out(ch)) m_out[ch] = d;
      if (w == 1 && b_in(ch))  m_mask[ch] = d;
      if (w == 2 && b_in(ch))  m_cap[ch] = m_cap[ch] & ~d;
    end
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    check(pin_out == exp_pins(), (mode_code(ch) == 0) ? "R5 pins after write" : "R2 pins after write",
          128'(pin_out), 128'(exp_pins()));
    check(irq == exp_irq(), "R8 irq after write", 128'(irq), 128'(exp_irq()));
  endtask

  task automatic bus_read(input int ch, input int w);
    logic [NUM_CH-1:0] es;
    logic [DW-1:0] ev;
    @(negedge clk);
    addr = AW'(ch * 4 + w); cs = 1'b1; rd = 1'b1;
    #1;
    es = (ch < NUM_CH && w == 0) ? NUM_CH'(1 << ch) : '0;
    check(usr_rd == es && usr_sel == es && usr_wr == '0, "R9 read strobes",
          128'({usr_sel, usr_rd, usr_wr}), 128'({es, es, {NUM_CH{1'b0}}}));
    ev = exp_read(ch, w);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    check(rdata == ev, read_tag(ch, w), 128'(rdata), 128'(ev));
    @(negedge clk);
    check(rdata == '0, "R6 rdata idle", 128'(rdata), 128'(0));
  endtask

  task automatic set_pins(input logic [NW-1:0] v);
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) begin
      if (b_in(c)) begin
        m_cap[c] = m_cap[c] | (v[c*DW +: DW] & ~m_pin[c]);
        m_pin[c] = v[c*DW +: DW];
      end
    end
    pin_in = v;
    repeat (3) @(negedge clk);
    check(irq == exp_irq(), "R7 irq after pin change", 128'(irq), 128'(exp_irq()));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed_q;
    logic [95:0] r96;
    seed_q = $urandom(32'd20240611);
    rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m_out[c] = '0; m_pin[c] = '0; m_mask[c] = '0; m_cap[c] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(pin_out == '0, "R1 reset pins", 128'(pin_out), 128'(0));
    check(rdata == '0, "R1 reset rdata", 128'(rdata), 128'(0));
    check(irq == 1'b0, "R1 reset irq", 128'(irq), 128'(0));
    for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) bus_read(c, w);

    // directed: data writes to every channel index, then read back
    for (int c = 0; c < 8; c++) bus_write(c, 0, DW'(16'hA500 + c));
    for (int c = 0; c < 8; c++) bus_read(c, 0);
    bus_write(1, 1, 16'hFFFF);   // R8: mask write on output-only channel ignored
    bus_read(1, 1);
    bus_write(4, 2, 16'hFFFF);   // R5: disabled channel ignores writes
    bus_read(4, 2);

    // directed edge capture and interrupt: R7 R8
    set_pins({NUM_CH{16'h00F0}});
    bus_read(0, 2);
    bus_read(2, 2);
    bus_write(2, 1, 16'h0010);   // unmask bit 4 of channel 2
    check(irq == 1'b1, "R8 irq on masked capture", 128'(irq), 128'(1));
    bus_write(2, 2, 16'h0000);   // writing zero keeps captures
    bus_read(2, 2);
    check(irq == 1'b1, "R8 irq held", 128'(irq), 128'(1));
    set_pins({NUM_CH{16'h000F}}); // falling bits 4..7 must not capture anew
    bus_write(2, 2, 16'h0010);   // clear bit 4 only
    bus_read(2, 2);
    check(irq == 1'b0, "R8 irq after clear", 128'(irq), 128'(0));
    bus_read(2, 0);
    bus_write(0, 2, 16'hFFFF);
    bus_write(2, 2, 16'hFFFF);

    // constrained random mix
    for (int k = 0; k < 500; k++) begin
      int op = int'($urandom % 8);
      int c  = int'($urandom % 8);
      int w  = int'($urandom % 4);
      logic [DW-1:0] d = DW'($urandom);
      if (op < 3) bus_write(c, w, d);
      else if (op < 6) bus_read(c, w);
      else if (op == 6) begin
        r96 = {$urandom, $urandom, $urandom};
        set_pins(r96[NW-1:0]);
      end else begin
        bus_write(c, 2, d);
        bus_read(c, 2);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule